// File: doc/BRIEF.md
# Fractional-Prescaled Microsecond Counter

This block keeps a free-running up-counter that advances at a slow reference rate, typically 1 MHz, while it is clocked from a faster peripheral clock. Rather than a whole-number divider, a fractional prescaler sets the tick rate. An accumulator adds a programmable numerator on every clock. Each time the total reaches a programmable denominator, it takes that denominator back off and issues one tick. Both fraction terms live in one configuration register, and each is stored as its value minus one. After reset the ratio is 1/12, so a 12 MHz clock gives a 1 MHz count with no setup.

Software reads the count through a small register port at any time. The count is read-only. It wraps silently at its full width and raises no interrupt. A freeze bit stops the count and the accumulator together, and clearing the bit resumes counting from the held state. Any write to the configuration register restarts the fraction from zero.

Top module: `frac_us_counter`

## Requirements
- R1: After reset the count is 0, the configuration register reads 0x0000000B, the freeze register reads 0 and reg_rdata is 0.
- R2: Register map: count at byte offset 0x00, configuration at 0x04 (bits 15:8 = numerator minus one, bits 7:0 = denominator minus one, upper bits read 0), freeze at 0x3C (bit 0). Other offsets read 0. Read data appears on reg_rdata on the clock after the one that samples reg_rd_en and holds the value the register had before that edge.
- R3: With numerator N and denominator D, N <= D, the count advances by floor(j*N/D) over j unfrozen clocks that follow a configuration write.
- R4: With the reset ratio, the count first reads 1 after exactly 12 counting clocks following reset release.
- R5: When N > D, the count advances by exactly one on every unfrozen clock.
- R6: While freeze bit 0 is 1, the count and the accumulator hold. After the bit clears, counting resumes from the held accumulator value.
- R7: A configuration write clears the accumulator, and the count does not advance on the clock that accepts that write.
- R8: Writes to the count offset have no effect on the count.
- R9: The count is CNT_W bits wide (default 32). It wraps from all ones to zero, and reads return it zero-extended to 32 bits.
- R10: The count changes by at most +1 per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Write strobe, sampled at the rising edge |
| reg_rd_en | input | 1 | Read strobe, sampled at the rising edge |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |

## Verification
The accumulator is never visible directly. A wrong remainder shows up only as a count increment that comes one or more clocks early or late. The bench therefore uses reads of the count to pin the clock on which each tick must occur: right after a configuration write, across a freeze, and after an unfreeze. A lost or kept remainder shows in the count within one denominator period, which is at most 256 clocks. A wrong clamp for ratios above one shows as a missing increment within two clocks.

// File: rtl/frac_us_pkg.sv
package frac_us_pkg;
  localparam int FRAC_W     = 8;
  localparam int REG_DATA_W = 32;
  localparam int REG_ADDR_W = 8;

  localparam logic [REG_ADDR_W-1:0] OFF_COUNT  = 8'h00;
  localparam logic [REG_ADDR_W-1:0] OFF_CFG    = 8'h04;
  localparam logic [REG_ADDR_W-1:0] OFF_FREEZE = 8'h3C;

  localparam logic [FRAC_W-1:0] RST_NUM_M1 = 8'h00;
  localparam logic [FRAC_W-1:0] RST_DEN_M1 = 8'h0B;

  typedef struct packed {
    logic [FRAC_W-1:0] num_m1;
    logic [FRAC_W-1:0] den_m1;
  } ratio_cfg_t;
endpackage

// File: rtl/frac_us_prescaler.sv
module frac_us_prescaler
  import frac_us_pkg::*;
#(
  parameter int FW = FRAC_W,
  localparam int ACC_W = FW + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             clr,
  input  logic [FW-1:0]    num_m1,
  input  logic [FW-1:0]    den_m1,
  output logic             tick,
  output logic [ACC_W-1:0] acc
);
  logic [ACC_W-1:0] acc_q, acc_d, step, modulus, sum, rem;
  logic             reach;

  always_comb begin
    step    = ACC_W'(num_m1) + ACC_W'(1);
    modulus = ACC_W'(den_m1) + ACC_W'(1);
    sum     = acc_q + step;
    reach   = (sum >= modulus);
    rem     = sum - modulus;
    // ratios above one: at most one tick per clock, keep the remainder bounded
    if (rem >= modulus) rem = modulus - ACC_W'(1);
    tick  = run && !clr && reach;
    acc_d = acc_q;
    if (clr)      acc_d = '0;
    else if (run) acc_d = reach ? rem : sum;
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_d;
  end

  assign acc = acc_q;
endmodule

// File: rtl/frac_us_count.sv
module frac_us_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/frac_us_regs.sv
module frac_us_regs
  import frac_us_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [REG_DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]      cnt,
  output logic [FRAC_W-1:0]     num_m1,
  output logic [FRAC_W-1:0]     den_m1,
  output logic                  frz,
  output logic                  cfg_wr,
  output logic [REG_DATA_W-1:0] rdata
);
  ratio_cfg_t cfg_q;
  logic       frz_q;
  logic       unused_wbits;

  assign cfg_wr       = wr_en && (addr == OFF_CFG);
  assign unused_wbits = ^wdata[REG_DATA_W-1:2*FRAC_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '{num_m1: RST_NUM_M1, den_m1: RST_DEN_M1};
      frz_q <= 1'b0;
    end else if (wr_en) begin
      if (addr == OFF_CFG)    cfg_q <= ratio_cfg_t'(wdata[2*FRAC_W-1:0]);
      if (addr == OFF_FREEZE) frz_q <= wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) begin
      case (addr)
        OFF_COUNT:  rdata <= REG_DATA_W'(cnt);
        OFF_CFG:    rdata <= REG_DATA_W'(cfg_q);
        OFF_FREEZE: rdata <= REG_DATA_W'(frz_q);
        default:    rdata <= '0;
      endcase
    end
  end

  assign num_m1 = cfg_q.num_m1;
  assign den_m1 = cfg_q.den_m1;
  assign frz    = frz_q;
endmodule

// File: rtl/frac_us_counter.sv
module frac_us_counter
  import frac_us_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr_en,
  input  logic                  reg_rd_en,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [REG_DATA_W-1:0] reg_wdata,
  output logic [REG_DATA_W-1:0] reg_rdata
);
  localparam int ACC_W = FRAC_W + 2;

  logic [FRAC_W-1:0] num_m1, den_m1;
  logic              frz, cfg_wr, tick;
  logic [ACC_W-1:0]  acc_w;
  logic [CNT_W-1:0]  cnt_w;

  frac_us_regs #(.CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .rd_en(reg_rd_en),
    .addr(reg_addr), .wdata(reg_wdata), .cnt(cnt_w),
    .num_m1(num_m1), .den_m1(den_m1), .frz(frz), .cfg_wr(cfg_wr),
    .rdata(reg_rdata)
  );

  frac_us_prescaler #(.FW(FRAC_W)) pre_i (
    .clk(clk), .rst(rst), .run(!frz), .clr(cfg_wr),
    .num_m1(num_m1), .den_m1(den_m1), .tick(tick), .acc(acc_w)
  );

  frac_us_count #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst(rst), .tick(tick), .cnt(cnt_w)
  );
endmodule

// File: rtl/frac_us_checker.sv
module frac_us_checker #(
  parameter int CNT_W = 32,
  parameter int FW    = 8,
  localparam int ACC_W = FW + 2
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_wr,
  input logic             frz,
  input logic [FW-1:0]    den_m1,
  input logic [ACC_W-1:0] acc,
  input logic [CNT_W-1:0] cnt
);
  // R10: at most one step per clock
  a_r10_single_step: assert property (@(posedge clk) disable iff (rst)
    !$stable(cnt) |-> cnt == $past(cnt) + CNT_W'(1));

  // R6: freeze holds both count and accumulator
  a_r6_freeze_hold: assert property (@(posedge clk) disable iff (rst)
    frz |=> ($stable(cnt) && $stable(acc)));

  // R7: configuration write clears remainder without a tick
  a_r7_cfg_clear: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> (acc == '0 && $stable(cnt)));

  // R3: remainder stays below the denominator
  a_r3_acc_bound: assert property (@(posedge clk) disable iff (rst)
    acc <= ACC_W'(den_m1));
endmodule

bind frac_us_counter frac_us_checker #(.CNT_W(CNT_W), .FW(frac_us_pkg::FRAC_W)) chk_i (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .frz(frz),
  .den_m1(den_m1), .acc(acc_w), .cnt(cnt_w)
);

// File: tb/frac_us_counter_tb_top.sv
`timescale 1ns/1ps
module frac_us_counter_tb_top;
  import frac_us_pkg::*;

  localparam int TB_CNT_W = 8;
  localparam logic [31:0] CNT_MASK = (32'd1 << TB_CNT_W) - 32'd1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic        reg_rd_en = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  frac_us_counter #(.CNT_W(TB_CNT_W)) dut_i (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // every operation below uses exactly one rising edge, starting at a falling edge
  task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [7:0] a, output logic [31:0] d);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_and_default();
    logic [31:0] v;
    rst = 1'b1;
    idle(4);
    rst = 1'b0;
    chk("R1 rdata after reset", reg_rdata, 32'h0);
    do_rd(OFF_CFG, v);    chk("R1 cfg reset value", v, 32'h0000_000B);
    do_rd(OFF_FREEZE, v); chk("R1 freeze reset value", v, 32'h0);
    do_rd(OFF_COUNT, v);  chk("R1 count reset value", v, 32'h0);
    idle(8);
    do_rd(OFF_COUNT, v);  chk("R4 no tick before clock 12", v, 32'h0);
    do_rd(OFF_COUNT, v);  chk("R4 first tick at clock 12", v, 32'h1);
  endtask

  task automatic t_ratio(input logic [15:0] cfg, input int m, input string req);
    logic [31:0] b, c, rb;
    int n, d, j, inc;
    do_wr(OFF_CFG, {16'hA5A5, cfg});
    do_rd(OFF_COUNT, b);
    idle(m);
    do_rd(OFF_COUNT, c);
    n = int'(cfg[15:8]) + 1;
    d = int'(cfg[7:0]) + 1;
    j = m + 1;
    inc = (n >= d) ? j : (j * n) / d;
    chk(req, c, (b + 32'(inc)) & CNT_MASK);
    do_rd(OFF_CFG, rb);
    chk("R2 cfg readback", rb, {16'h0, cfg});
  endtask

  task automatic t_freeze_and_ro();
    logic [31:0] b, v;
    do_wr(OFF_CFG, 32'h0000_0003);      // ratio 1/4
    do_rd(OFF_COUNT, b);                // returns value right after the write
    idle(1);
    do_wr(OFF_FREEZE, 32'h1);           // third clock counts, remainder 3
    do_rd(OFF_FREEZE, v); chk("R2 freeze readback", v, 32'h1);
    do_rd(OFF_COUNT, v);  chk("R6 count held", v, b);
    idle(20);
    do_wr(OFF_COUNT, 32'h0000_005A);
    do_rd(OFF_COUNT, v);  chk("R8 count write ignored", v, b);
    do_wr(OFF_FREEZE, 32'h0);
    do_rd(OFF_COUNT, v);  chk("R6 still held on resume edge", v, b);
    do_rd(OFF_COUNT, v);  chk("R6 remainder kept across freeze", v, (b + 32'd1) & CNT_MASK);
  endtask

  task automatic t_cfg_clear();
    logic [31:0] b, v;
    do_wr(OFF_CFG, 32'h0000_0003);
    idle(2);
    do_wr(OFF_CFG, 32'h0000_0003);
    do_rd(OFF_COUNT, b);
    idle(2);
    do_rd(OFF_COUNT, v);  chk("R7 remainder cleared, no early tick", v, b);
    do_rd(OFF_COUNT, v);  chk("R7 tick after full period", v, (b + 32'd1) & CNT_MASK);
    do_wr(OFF_CFG, 32'h0000_0000);      // ratio 1/1
    do_rd(OFF_COUNT, b);
    do_wr(OFF_CFG, 32'h0000_0000);
    do_rd(OFF_COUNT, v);  chk("R7 no advance on cfg write edge", v, (b + 32'd1) & CNT_MASK);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    do_rd(8'h10, v); chk("R2 unmapped offset reads zero", v, 32'h0);
  endtask

  initial begin
    idle(1);
    t_reset_and_default();
    t_ratio(16'h0206, 20,  "R3 ratio 3/7");
    t_ratio(16'h0B0F, 30,  "R3 ratio 12/16");
    t_ratio(16'hFFFF, 3,   "R3 ratio 256/256");
    t_ratio(16'h0401, 7,   "R5 ratio 5/2 ticks every clock");
    t_ratio(16'h0000, 300, "R9 wrap at 1/1");
    t_freeze_and_ro();
    t_cfg_clear();
    t_unmapped();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule